// File: doc/BRIEF.md
# Receive Frame Address Filter

This block sits behind the header parser of a wireless LAN receive path. For every received frame header it reports whether the first address is broadcast, multicast or addressed to this station, whether the third address names this station's BSS, and whether the frame should be thrown away. The parser offers the frame type and subtype, the ToDS bit, the protocol version, address 1, address 3 and the CRC-error and PHY-error flags with a one-cycle `hdr_valid` strobe. One cycle later the block returns its verdict on a matching `res_valid` strobe.

A small write-only configuration port holds the station address, the BSSID, a unicast mask byte, a two-bit BSS mode and one drop enable per frame category. The low bits of address byte 5 can be left out of both compares. This lets one receiver answer for one, two or four BSSIDs at once. Each drop reason can be switched on or off by itself, and a global receive-off bit discards everything.

Top module: `rx_addr_filter`

## Requirements
- R1: After a synchronous active-low reset all outputs are 0. The configuration resets to station address 0, BSSID 0, unicast mask 0xFF, BSS mode 0 and all drop enables 0.
- R2: `res_valid` is high exactly in the cycle after a cycle with `hdr_valid` high. The four flags and `res_drop` are loaded only on such frames and hold their value otherwise.
- R3: Byte 0 of an address is bits 7:0 and byte 5 is bits 47:40. Broadcast is address 1 equal to all ones. Multicast is address 1 with bit 0 set and not broadcast.
- R4: Unicast-to-me requires bit 0 of address 1 to be clear and address 1 to equal the station address. Bytes 0 to 4 are compared in full. On byte 5 only the bits set in (BSS mask AND unicast mask) are compared. The station address is written at index 0 (bits 31:0) and index 1 (bits 47:32 in data 15:0, unicast mask in data 23:16).
- R5: The BSS mode sets the BSS mask for byte 5: mode 0 gives 0xFF (one BSSID), mode 1 gives 0xFE (two BSSIDs, index bit 0), mode 2 gives 0xFD (two BSSIDs, index bit 1), mode 3 gives 0xFC (four BSSIDs, bits 1:0). My-BSS is address 3 equal to the BSSID, with byte 5 compared only under the BSS mask. The BSSID is written at index 2 (bits 31:0) and index 3 (bits 47:32 in data 15:0, mode in data 17:16).
- R6: The drop enables are written at index 4, data 9:0. Bit 1 drops frames with a CRC error. Bit 2 drops frames with a PHY error. Bit 3 drops control frames (type 01). Bit 5 drops frames with ToDS set. Bit 6 drops frames whose protocol version is not 0.
- R7: Enable bit 4 drops frames that are neither unicast-to-me, multicast nor broadcast. Bit 7 drops multicast frames. Bit 8 drops broadcast frames. Bit 9 drops control frames with subtype 1101 (ACK) or 1100 (CTS).
- R8: Enable bit 0 drops every frame, whatever its contents.
- R9: `res_drop` is the OR of all enabled conditions that match. With no enabled condition matching it is 0.
- R10: A configuration write in the same cycle as `hdr_valid` does not affect that frame. The frame is judged against the settings from before the write.
- R11: Writes to indices 5 to 7 change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| hdr_valid | input | 1 | Header fields valid this cycle |
| hdr_type | input | 2 | Frame type |
| hdr_subtype | input | 4 | Frame subtype |
| hdr_to_ds | input | 1 | ToDS bit |
| hdr_version | input | 2 | Protocol version |
| hdr_addr1 | input | 48 | Address 1 (receiver) |
| hdr_addr3 | input | 48 | Address 3 (BSSID field) |
| hdr_crc_err | input | 1 | Frame failed its CRC |
| hdr_phy_err | input | 1 | PHY reported an error |
| res_valid | output | 1 | Verdict strobe, one cycle after `hdr_valid` |
| res_ucast_me | output | 1 | Address 1 is this station |
| res_mcast | output | 1 | Address 1 is multicast |
| res_bcast | output | 1 | Address 1 is broadcast |
| res_my_bss | output | 1 | Address 3 is this BSS |
| res_drop | output | 1 | Frame is to be discarded |

## Verification
The two functions that can meet in one cycle are a configuration write and a header classification. The bench raises `cfg_wr_en` and `hdr_valid` together, for example enabling the CRC drop while a CRC-failed frame is presented. It expects that frame to pass and the next identical frame to be dropped. The behavioural model in the bench evaluates each frame before applying any write from the same cycle, and every clock it compares the whole result vector against the design.

// File: rtl/rxf_pkg.sv
// Package rxf_pkg: shared sizes, drop-category indices and the
// configuration / classification structures of the receive filter.
package rxf_pkg;
    parameter int MAC_BYTES = 6;
    localparam int MAC_W    = MAC_BYTES * 8;
    localparam int DATA_W   = 32;
    localparam int CFG_AW   = 3;
    localparam int TYPE_W   = 2;
    localparam int SUB_W    = 4;
    localparam int VER_W    = 2;
    localparam int MODE_W   = 2;

    // Drop-enable bit positions (software-visible, part of the register map)
    localparam int DB_RXOFF  = 0;
    localparam int DB_CRC    = 1;
    localparam int DB_PHY    = 2;
    localparam int DB_CTRL   = 3;
    localparam int DB_NOTME  = 4;
    localparam int DB_TODS   = 5;
    localparam int DB_VER    = 6;
    localparam int DB_MCAST  = 7;
    localparam int DB_BCAST  = 8;
    localparam int DB_ACKCTS = 9;
    localparam int DROP_N    = 10;

    // Register indices
    localparam logic [CFG_AW-1:0] RI_STA_LO = 3'd0;
    localparam logic [CFG_AW-1:0] RI_STA_HI = 3'd1;
    localparam logic [CFG_AW-1:0] RI_BSS_LO = 3'd2;
    localparam logic [CFG_AW-1:0] RI_BSS_HI = 3'd3;
    localparam logic [CFG_AW-1:0] RI_DROP   = 3'd4;

    // Frame header codes
    localparam logic [TYPE_W-1:0] FT_CTRL    = 2'b01;
    localparam logic [SUB_W-1:0]  ST_ACK     = 4'b1101;
    localparam logic [SUB_W-1:0]  ST_CTS     = 4'b1100;
    localparam logic [VER_W-1:0]  PROTO_VER0 = 2'b00;

    typedef enum logic [MODE_W-1:0] {
        BSS_ONE    = 2'd0,
        BSS_TWO_B0 = 2'd1,
        BSS_TWO_B1 = 2'd2,
        BSS_FOUR   = 2'd3
    } bss_mode_e;

    typedef struct packed {
        logic [MAC_W-1:0]  sta;
        logic [7:0]        uc_mask;
        logic [MAC_W-1:0]  bssid;
        bss_mode_e         mode;
        logic [DROP_N-1:0] drop_en;
    } rxf_cfg_t;

    typedef struct packed {
        logic ucast_me;
        logic mcast;
        logic bcast;
        logic my_bss;
    } rxf_cls_t;
endpackage

// File: rtl/rxf_cfg_regs.sv
// rxf_cfg_regs: write-only configuration store of the receive filter.
// Assumes one write per cycle; indices outside the map are ignored.
// A write takes effect from the cycle after the strobe.
module rxf_cfg_regs
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output rxf_cfg_t          cfg
);
    localparam int HI_W = MAC_W - 32;

    // Register update: reset to defaults, otherwise load the addressed field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.sta     <= '0;
            cfg.uc_mask <= 8'hFF;
            cfg.bssid   <= '0;
            cfg.mode    <= BSS_ONE;
            cfg.drop_en <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RI_STA_LO: cfg.sta[31:0] <= wr_data[31:0];
                RI_STA_HI: begin
                    cfg.sta[MAC_W-1:32] <= wr_data[HI_W-1:0];
                    cfg.uc_mask         <= wr_data[HI_W+7:HI_W];
                end
                RI_BSS_LO: cfg.bssid[31:0] <= wr_data[31:0];
                RI_BSS_HI: begin
                    cfg.bssid[MAC_W-1:32] <= wr_data[HI_W-1:0];
                    cfg.mode              <= bss_mode_e'(wr_data[HI_W+MODE_W-1:HI_W]);
                end
                RI_DROP:   cfg.drop_en <= wr_data[DROP_N-1:0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/rxf_addr_match.sv
// rxf_addr_match: combinational address classification.
// Compares address 1 with the station address and address 3 with the
// BSSID byte by byte; byte 5 is compared under a mask derived from the
// BSS mode (and, for the station, the unicast mask as well).
module rxf_addr_match
    import rxf_pkg::*;
(
    input  rxf_cfg_t         cfg,
    input  logic [MAC_W-1:0] addr1,
    input  logic [MAC_W-1:0] addr3,
    output rxf_cls_t         cls
);
    localparam int LAST = MAC_BYTES - 1;

    logic [7:0]           bss_keep;
    logic [7:0]           uc_keep;
    logic [MAC_BYTES-1:0] sta_eq;
    logic [MAC_BYTES-1:0] bss_eq;

    // Mode decode: which byte-5 bits identify the BSS and are ignored
    always_comb begin
        case (cfg.mode)
            BSS_ONE:    bss_keep = 8'hFF;
            BSS_TWO_B0: bss_keep = 8'hFE;
            BSS_TWO_B1: bss_keep = 8'hFD;
            default:    bss_keep = 8'hFC;
        endcase
    end

    assign uc_keep = bss_keep & cfg.uc_mask;

    // Per-byte compares; only the last byte carries a mask
    for (genvar b = 0; b < MAC_BYTES; b++) begin : g_byte
        if (b == LAST) begin : g_masked
            assign sta_eq[b] = ((addr1[8*b +: 8] ^ cfg.sta[8*b +: 8])   & uc_keep)  == 8'h00;
            assign bss_eq[b] = ((addr3[8*b +: 8] ^ cfg.bssid[8*b +: 8]) & bss_keep) == 8'h00;
        end else begin : g_full
            assign sta_eq[b] = addr1[8*b +: 8] == cfg.sta[8*b +: 8];
            assign bss_eq[b] = addr3[8*b +: 8] == cfg.bssid[8*b +: 8];
        end
    end

    // Flag assembly from the byte results and the group bit
    always_comb begin
        cls.bcast    = &addr1;
        cls.mcast    = addr1[0] & ~cls.bcast;
        cls.ucast_me = ~addr1[0] & (&sta_eq);
        cls.my_bss   = &bss_eq;
    end
endmodule

// File: rtl/rxf_drop_eval.sv
// rxf_drop_eval: combinational drop decision.
// Builds one hit bit per drop category and ORs the enabled ones.
// Assumes the classification flags come from the same header.
module rxf_drop_eval
    import rxf_pkg::*;
(
    input  logic [DROP_N-1:0] drop_en,
    input  rxf_cls_t          cls,
    input  logic [TYPE_W-1:0] ftype,
    input  logic [SUB_W-1:0]  fsub,
    input  logic              to_ds,
    input  logic [VER_W-1:0]  version,
    input  logic              crc_err,
    input  logic              phy_err,
    output logic              drop
);
    logic [DROP_N-1:0] hit;
    logic              is_ctrl;

    assign is_ctrl = ftype == FT_CTRL;

    // Category hits, indexed by the drop-enable bit positions
    always_comb begin
        hit            = '0;
        hit[DB_RXOFF]  = 1'b1;
        hit[DB_CRC]    = crc_err;
        hit[DB_PHY]    = phy_err;
        hit[DB_CTRL]   = is_ctrl;
        hit[DB_NOTME]  = ~(cls.ucast_me | cls.mcast | cls.bcast);
        hit[DB_TODS]   = to_ds;
        hit[DB_VER]    = version != PROTO_VER0;
        hit[DB_MCAST]  = cls.mcast;
        hit[DB_BCAST]  = cls.bcast;
        hit[DB_ACKCTS] = is_ctrl & ((fsub == ST_ACK) | (fsub == ST_CTS));
    end

    assign drop = |(hit & drop_en);
endmodule

// File: rtl/rx_addr_filter.sv
// rx_addr_filter: receive frame address filter top.
// Classifies each header offered with hdr_valid and registers the
// flags and drop verdict, strobing res_valid one cycle later. The
// flags hold between frames. Configuration writes in the same cycle
// as a header apply only to later headers.
module rx_addr_filter
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              hdr_valid,
    input  logic [TYPE_W-1:0] hdr_type,
    input  logic [SUB_W-1:0]  hdr_subtype,
    input  logic              hdr_to_ds,
    input  logic [VER_W-1:0]  hdr_version,
    input  logic [MAC_W-1:0]  hdr_addr1,
    input  logic [MAC_W-1:0]  hdr_addr3,
    input  logic              hdr_crc_err,
    input  logic              hdr_phy_err,
    output logic              res_valid,
    output logic              res_ucast_me,
    output logic              res_mcast,
    output logic              res_bcast,
    output logic              res_my_bss,
    output logic              res_drop
);
    rxf_cfg_t cfg_q;
    rxf_cls_t cls_now;
    logic     drop_now;

    rxf_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .cfg     (cfg_q)
    );

    rxf_addr_match u_match (
        .cfg   (cfg_q),
        .addr1 (hdr_addr1),
        .addr3 (hdr_addr3),
        .cls   (cls_now)
    );

    rxf_drop_eval u_drop (
        .drop_en (cfg_q.drop_en),
        .cls     (cls_now),
        .ftype   (hdr_type),
        .fsub    (hdr_subtype),
        .to_ds   (hdr_to_ds),
        .version (hdr_version),
        .crc_err (hdr_crc_err),
        .phy_err (hdr_phy_err),
        .drop    (drop_now)
    );

    // Result register: strobe every cycle, flags only on a header
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_ucast_me <= 1'b0;
            res_mcast    <= 1'b0;
            res_bcast    <= 1'b0;
            res_my_bss   <= 1'b0;
            res_drop     <= 1'b0;
        end else begin
            res_valid <= hdr_valid;
            if (hdr_valid) begin
                res_ucast_me <= cls_now.ucast_me;
                res_mcast    <= cls_now.mcast;
                res_bcast    <= cls_now.bcast;
                res_my_bss   <= cls_now.my_bss;
                res_drop     <= drop_now;
            end
        end
    end
endmodule

// File: rtl/rxf_checker.sv
// rxf_checker: temporal properties of the receive filter, bound to the top.
module rxf_checker
    import rxf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             hdr_valid,
    input logic [MAC_W-1:0] hdr_addr1,
    input logic             rx_off,
    input logic             res_valid,
    input logic             res_ucast_me,
    input logic             res_mcast,
    input logic             res_bcast,
    input logic             res_my_bss,
    input logic             res_drop
);
    assert_valid_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> res_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !res_valid);

    assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> $stable({res_ucast_me, res_mcast, res_bcast, res_my_bss, res_drop}));

    assert_group_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(res_mcast && res_bcast));

    assert_bcast_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && (&hdr_addr1)) |=> res_bcast);

    assert_ucast_not_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_ucast_me |-> (!res_mcast && !res_bcast));

    assert_rx_off_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && rx_off) |=> res_drop);

    assert_unused_my_bss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> $stable(res_my_bss));
endmodule

bind rx_addr_filter rxf_checker u_rxf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .hdr_valid    (hdr_valid),
    .hdr_addr1    (hdr_addr1),
    .rx_off       (cfg_q.drop_en[0]),
    .res_valid    (res_valid),
    .res_ucast_me (res_ucast_me),
    .res_mcast    (res_mcast),
    .res_bcast    (res_bcast),
    .res_my_bss   (res_my_bss),
    .res_drop     (res_drop)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        hdr_valid = 1'b0;
    logic [1:0]  hdr_type = '0;
    logic [3:0]  hdr_subtype = '0;
    logic        hdr_to_ds = 1'b0;
    logic [1:0]  hdr_version = '0;
    logic [47:0] hdr_addr1 = '0;
    logic [47:0] hdr_addr3 = '0;
    logic        hdr_crc_err = 1'b0;
    logic        hdr_phy_err = 1'b0;
    logic        res_valid, res_ucast_me, res_mcast, res_bcast, res_my_bss, res_drop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [47:0] m_sta = '0, m_bss = '0;
    logic [7:0]  m_ucm = 8'hFF;
    logic [1:0]  m_mode = 2'd0;
    logic [9:0]  m_en = '0;
    logic [5:0]  exp_v = '0;   // {valid, ucast, mcast, bcast, mybss, drop}

    localparam logic [47:0] STA = 48'h3C4433221102;
    localparam logic [47:0] BSS = 48'h7B556677880A;
    localparam logic [47:0] BC  = 48'hFFFFFFFFFFFF;

    always #5 clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hdr_valid(hdr_valid), .hdr_type(hdr_type),
        .hdr_subtype(hdr_subtype), .hdr_to_ds(hdr_to_ds), .hdr_version(hdr_version),
        .hdr_addr1(hdr_addr1), .hdr_addr3(hdr_addr3), .hdr_crc_err(hdr_crc_err),
        .hdr_phy_err(hdr_phy_err), .res_valid(res_valid), .res_ucast_me(res_ucast_me),
        .res_mcast(res_mcast), .res_bcast(res_bcast), .res_my_bss(res_my_bss),
        .res_drop(res_drop)
    );

    function automatic logic [7:0] keep_of(input logic [1:0] mode);
        logic [7:0] k = 8'hFF;
        if (mode == 2'd1) k[0] = 1'b0;
        if (mode == 2'd2) k[1] = 1'b0;
        if (mode == 2'd3) k[1:0] = 2'b00;
        return k;
    endfunction

    // Behavioural expectation for the header currently on the inputs
    function automatic logic [4:0] model_eval();
        logic bc, mc, uc, mb, dr;
        logic [7:0] k, ku;
        k  = keep_of(m_mode);
        ku = k & m_ucm;
        bc = (hdr_addr1 == BC);
        mc = hdr_addr1[0] && !bc;
        uc = !hdr_addr1[0] && (hdr_addr1[39:0] == m_sta[39:0])
             && ((hdr_addr1[47:40] & ku) == (m_sta[47:40] & ku));
        mb = (hdr_addr3[39:0] == m_bss[39:0])
             && ((hdr_addr3[47:40] & k) == (m_bss[47:40] & k));
        dr = 1'b0;
        if (m_en[0]) dr = 1'b1;
        if (m_en[1] && hdr_crc_err) dr = 1'b1;
        if (m_en[2] && hdr_phy_err) dr = 1'b1;
        if (m_en[3] && hdr_type == 2'b01) dr = 1'b1;
        if (m_en[4] && !uc && !mc && !bc) dr = 1'b1;
        if (m_en[5] && hdr_to_ds) dr = 1'b1;
        if (m_en[6] && hdr_version != 2'b00) dr = 1'b1;
        if (m_en[7] && mc) dr = 1'b1;
        if (m_en[8] && bc) dr = 1'b1;
        if (m_en[9] && hdr_type == 2'b01 && (hdr_subtype == 4'hD || hdr_subtype == 4'hC)) dr = 1'b1;
        return {uc, mc, bc, mb, dr};
    endfunction

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%b exp=%b (valid,ucast,mcast,bcast,mybss,drop)", tag, act, exp);
        end
    endtask

    // One clock: predict, update model config, advance, compare
    task automatic tick(input string tag);
        if (hdr_valid) exp_v = {1'b1, model_eval()};
        else           exp_v[5] = 1'b0;
        if (cfg_wr_en) begin
            case (cfg_addr)
                3'd0: m_sta[31:0] = cfg_wdata;
                3'd1: begin m_sta[47:32] = cfg_wdata[15:0]; m_ucm = cfg_wdata[23:16]; end
                3'd2: m_bss[31:0] = cfg_wdata;
                3'd3: begin m_bss[47:32] = cfg_wdata[15:0]; m_mode = cfg_wdata[17:16]; end
                3'd4: m_en = cfg_wdata[9:0];
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        check(tag, {res_valid, res_ucast_me, res_mcast, res_bcast, res_my_bss, res_drop}, exp_v);
        hdr_valid = 1'b0;
        cfg_wr_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick(tag);
    endtask

    task automatic set_sta(input logic [47:0] a, input logic [7:0] ucm, input string tag);
        wr(3'd0, a[31:0], tag);
        wr(3'd1, {8'h00, ucm, a[47:32]}, tag);
    endtask

    task automatic set_bss(input logic [47:0] a, input logic [1:0] mode, input string tag);
        wr(3'd2, a[31:0], tag);
        wr(3'd3, {14'h0, mode, a[47:32]}, tag);
    endtask

    task automatic frame(input logic [47:0] a1, input logic [47:0] a3, input logic [1:0] ty,
                         input logic [3:0] st, input logic tods, input logic [1:0] ver,
                         input logic crc, input logic phy, input string tag);
        hdr_addr1 = a1; hdr_addr3 = a3; hdr_type = ty; hdr_subtype = st;
        hdr_to_ds = tods; hdr_version = ver; hdr_crc_err = crc; hdr_phy_err = phy;
        hdr_valid = 1'b1;
        tick(tag);
    endtask

    task automatic dframe(input logic [47:0] a1, input logic [47:0] a3, input string tag);
        frame(a1, a3, 2'b10, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: act=hung exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", {res_valid, res_ucast_me, res_mcast, res_bcast, res_my_bss, res_drop}, 6'b0);
        rst_n = 1'b1;
        tick("R1 idle");
        // reset config: zero addresses, exact compare, no drops
        dframe(48'h0, 48'h0, "R1 default config");
        dframe(48'h0, 48'h1, "R1 default config");

        set_sta(STA, 8'hFF, "R4 cfg");
        set_bss(BSS, 2'd0, "R5 cfg");
        // R3 / R4 basic classification
        dframe(BC, BSS, "R3 broadcast");
        dframe(48'h0000000000A1, BSS, "R3 multicast");
        dframe(48'hFFFFFFFFFFFE, BSS, "R3 near-broadcast unicast");
        dframe(STA, BSS, "R4 exact match");
        dframe(STA ^ 48'h010000000000, BSS, "R4 byte5 bit0 differs mode0");
        dframe(STA ^ 48'h000000000100, BSS, "R4 byte1 differs");
        // R2: inputs change with no strobe, outputs hold
        hdr_addr1 = BC; hdr_crc_err = 1'b1;
        tick("R2 hold");
        tick("R2 hold");
        frame(STA, 48'h0, 2'b10, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0, "R2 back-to-back a");
        frame(BC, BSS, 2'b10, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0, "R2 back-to-back b");

        // R4 / R5 mask behaviour
        set_bss(BSS, 2'd1, "R5 mode1");
        dframe(STA ^ 48'h010000000000, BSS ^ 48'h010000000000, "R5 mode1 bit0 ignored");
        dframe(STA ^ 48'h020000000000, BSS ^ 48'h020000000000, "R5 mode1 bit1 compared");
        set_bss(BSS, 2'd2, "R5 mode2");
        dframe(STA ^ 48'h020000000000, BSS ^ 48'h020000000000, "R5 mode2 bit1 ignored");
        dframe(STA ^ 48'h010000000000, BSS ^ 48'h010000000000, "R5 mode2 bit0 compared");
        set_bss(BSS, 2'd3, "R5 mode3");
        dframe(STA ^ 48'h030000000000, BSS ^ 48'h030000000000, "R5 mode3 bits1:0 ignored");
        dframe(STA ^ 48'h040000000000, BSS ^ 48'h040000000000, "R5 mode3 bit2 compared");
        set_sta(STA, 8'h7F, "R4 ucast mask");
        dframe(STA ^ 48'h800000000000, BSS, "R4 masked bit7 ignored");
        set_bss(BSS, 2'd0, "R4 mode0");
        dframe(STA ^ 48'h800000000000, BSS, "R4 combined mask mode0");
        dframe(STA ^ 48'h010000000000, BSS, "R4 combined mask bit0 compared");
        set_sta(STA, 8'hFF, "R4 restore");

        // R6 individual enables
        wr(3'd4, 32'h002, "R6 crc en");
        frame(STA, BSS, 2'b10, 4'h0, 1'b0, 2'b00, 1'b1, 1'b0, "R6 crc drop");
        frame(STA, BSS, 2'b10, 4'h0, 1'b0, 2'b00, 1'b0, 1'b1, "R6 phy not enabled");
        wr(3'd4, 32'h004, "R6 phy en");
        frame(STA, BSS, 2'b10, 4'h0, 1'b0, 2'b00, 1'b0, 1'b1, "R6 phy drop");
        wr(3'd4, 32'h008, "R6 ctrl en");
        frame(STA, BSS, 2'b01, 4'hB, 1'b0, 2'b00, 1'b0, 1'b0, "R6 control drop");
        frame(STA, BSS, 2'b00, 4'h8, 1'b0, 2'b00, 1'b0, 1'b0, "R6 mgmt pass");
        wr(3'd4, 32'h020, "R6 tods en");
        frame(STA, BSS, 2'b10, 4'h0, 1'b1, 2'b00, 1'b0, 1'b0, "R6 tods drop");
        wr(3'd4, 32'h040, "R6 version en");
        frame(STA, BSS, 2'b10, 4'h0, 1'b0, 2'b01, 1'b0, 1'b0, "R6 bad version drop");
        frame(STA, BSS, 2'b10, 4'h0, 1'b0, 2'b00, 1'b0, 1'b0, "R6 good version pass");

        // R7 address enables
        wr(3'd4, 32'h010, "R7 not-to-me en");
        dframe(48'h0000000000A0, BSS, "R7 other unicast drop");
        dframe(48'h0000000000A1, BSS, "R7 multicast not affected");
        dframe(STA, BSS, "R7 to me pass");
        wr(3'd4, 32'h080, "R7 mcast en");
        dframe(48'h0000000000A1, BSS, "R7 multicast drop");
        dframe(BC, BSS, "R7 broadcast not mcast");
        wr(3'd4, 32'h100, "R7 bcast en");
        dframe(BC, BSS, "R7 broadcast drop");
        wr(3'd4, 32'h200, "R7 ackcts en");
        frame(STA, BSS, 2'b01, 4'hD, 1'b0, 2'b00, 1'b0, 1'b0, "R7 ACK drop");
        frame(STA, BSS, 2'b01, 4'hC, 1'b0, 2'b00, 1'b0, 1'b0, "R7 CTS drop");
        frame(STA, BSS, 2'b01, 4'hB, 1'b0, 2'b00, 1'b0, 1'b0, "R7 RTS pass");
        frame(STA, BSS, 2'b10, 4'hD, 1'b0, 2'b00, 1'b0, 1'b0, "R7 data subtype D pass");

        // R8 receive off
        wr(3'd4, 32'h001, "R8 rx off");
        dframe(STA, BSS, "R8 clean frame dropped");
        dframe(BC, 48'h0, "R8 broadcast dropped");

        // R9 OR of conditions, and all-enabled with no hit
        wr(3'd4, 32'h3FE, "R9 all but rxoff");
        dframe(STA, BSS, "R9 no condition");
        frame(BC, BSS, 2'b01, 4'hD, 1'b1, 2'b11, 1'b1, 1'b1, "R9 many conditions");
        wr(3'd4, 32'h000, "R9 none enabled");
        frame(BC, BSS, 2'b01, 4'hD, 1'b1, 2'b11, 1'b1, 1'b1, "R9 nothing enabled");

        // R10 write coincident with a header
        cfg_wr_en = 1'b1; cfg_addr = 3'd4; cfg_wdata = 32'h002;
        frame(STA, BSS, 2'b10, 4'h0, 1'b0, 2'b00, 1'b1, 1'b0, "R10 old settings");
        frame(STA, BSS, 2'b10, 4'h0, 1'b0, 2'b00, 1'b1, 1'b0, "R10 new settings");
        cfg_wr_en = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'h0;
        dframe(STA, BSS, "R10 station write same cycle");
        dframe(STA, BSS, "R10 station write applied");
        set_sta(STA, 8'hFF, "R10 restore");
        wr(3'd4, 32'h000, "R10 restore");

        // R11 unmapped indices
        wr(3'd5, 32'hFFFFFFFF, "R11 idx5");
        wr(3'd6, 32'hFFFFFFFF, "R11 idx6");
        wr(3'd7, 32'hFFFFFFFF, "R11 idx7");
        dframe(STA, BSS, "R11 settings unchanged");
        frame(48'h0000000000A1, BSS, 2'b01, 4'hD, 1'b1, 2'b01, 1'b1, 1'b1, "R11 no drop enabled");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule